// File: doc/BRIEF.md
# Synchronous Dual-Port RAM with Per-Port Read Latency

This block is a clocked memory with two independent access ports, left and right. Each port has its own address, write strobe, a pair of chip selects (one active low, one active high), an output enable and two byte-lane enables. Both ports sample their inputs on the same clock edge. In any cycle they may each read or write any word, including the same word.

Each port has a static latency input. With it low, a read sampled on one edge returns data after that edge (flow-through). With it high, the data passes through one more register and appears one edge later (pipelined). Tri-state outputs are modelled as a pair of per-lane valid flags, and the data bits of a lane are driven to zero while its flag is low. The word width is a parameter that must be even. It defaults to 18 bits, so each lane is 9 bits, and setting it to 16 gives 8-bit lanes. The depth is set by the address width parameter.

Top module: `dpram_sync_top`

## Requirements
- R1: Both ports can be selected for reads in the same cycle, including of the same address, and each returns the stored word on its own outputs.
- R2: With the port's latency input low, a read sampled at clock edge N drives its data and valid flags from just after edge N until edge N+1.
- R3: With the port's latency input high, a read sampled at edge N drives its data and valid flags from just after edge N+1 until edge N+2.
- R4: A port is selected only while its active-low chip select is 0 and its active-high chip select is 1. An unselected port writes nothing, and the read cycle that follows it shows both valid flags low.
- R5: In a write, the upper lane enable controls bits [WORD_W-1:WORD_W/2] and the lower lane enable controls bits [WORD_W/2-1:0]. A lane whose enable is low keeps its stored value.
- R6: In a read, each lane's valid flag is set only if that lane's enable was high when the read was sampled. The data bits of an invalid lane read as zero.
- R7: While a port's output enable is low, both of its valid flags are low and its data output is zero.
- R8: If both ports write the same address in the same cycle, each lane the left port enables takes the left data. Lanes enabled only by the right port take the right data.
- R9: A read sampled in the same cycle as a write to that address on the other port returns the old word. A read one cycle later returns the new word.
- R10: After a synchronous active-low reset, both ports show low valid flags and zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset of the read paths |
| lf_addr | input | ADDR_W | Left word address |
| lf_we | input | 1 | Left write strobe (1 write, 0 read) |
| lf_ce_n | input | 1 | Left active-low chip select |
| lf_ce | input | 1 | Left active-high chip select |
| lf_oe | input | 1 | Left output enable |
| lf_ub | input | 1 | Left upper lane enable |
| lf_lb | input | 1 | Left lower lane enable |
| lf_pipe | input | 1 | Left latency select (0 flow-through, 1 pipelined) |
| lf_wdata | input | WORD_W | Left write data |
| lf_rdata | output | WORD_W | Left read data, zero in invalid lanes |
| lf_rv_hi | output | 1 | Left upper lane read data valid |
| lf_rv_lo | output | 1 | Left lower lane read data valid |
| rt_addr | input | ADDR_W | Right word address |
| rt_we | input | 1 | Right write strobe |
| rt_ce_n | input | 1 | Right active-low chip select |
| rt_ce | input | 1 | Right active-high chip select |
| rt_oe | input | 1 | Right output enable |
| rt_ub | input | 1 | Right upper lane enable |
| rt_lb | input | 1 | Right lower lane enable |
| rt_pipe | input | 1 | Right latency select |
| rt_wdata | input | WORD_W | Right write data |
| rt_rdata | output | WORD_W | Right read data, zero in invalid lanes |
| rt_rv_hi | output | 1 | Right upper lane read data valid |
| rt_rv_lo | output | 1 | Right lower lane read data valid |

## Verification
The checker runs on every cycle for each port. It covers the output-enable mask, the zeroing of invalid lanes, and the silence after a deselected cycle. It also checks that a selected read raises its lane flag after the right number of edges in each latency mode. Whether the returned word is correct can only be shown by the bench's reference array. The same goes for lane-masked writes, old-versus-new data when one port writes and the other reads, left-wins on shared write addresses, and writes dropped while deselected. Those outcomes depend on stored contents, not on a per-cycle port relation.

// File: rtl/dpr_pkg.sv
// Shared types for the dual-port RAM.
// Assumes a word is split into exactly two equal byte lanes.
package dpr_pkg;

    // Per-lane enable pair: upper half and lower half of a word.
    typedef struct packed {
        logic hi;
        logic lo;
    } lane_t;

    localparam int NUM_LANES = 2;

endpackage

// File: rtl/dpr_array.sv
// Storage array with two synchronous read/write ports.
// Reads are registered every cycle and return the contents from before the edge.
// When both ports write the same word, the port A write is ordered last, so A wins per lane.
// Assumes WORD_W is even.
module dpr_array
    import dpr_pkg::*;
#(
    parameter int WORD_W = 18,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              a_wr,
    input  lane_t             a_lanes,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [WORD_W-1:0] a_wdata,
    output logic [WORD_W-1:0] a_q,
    input  logic              b_wr,
    input  lane_t             b_lanes,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [WORD_W-1:0] b_wdata,
    output logic [WORD_W-1:0] b_q
);
    localparam int LANE_W = WORD_W / NUM_LANES;
    localparam int DEPTH  = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    logic [NUM_LANES-1:0] a_en, b_en;
    assign a_en = {a_lanes.hi, a_lanes.lo};
    assign b_en = {b_lanes.hi, b_lanes.lo};

    // Lane-masked writes (B first, A last so A wins), then registered reads.
    always_ff @(posedge clk) begin
        for (int k = 0; k < NUM_LANES; k++) begin
            if (b_wr && b_en[k])
                mem[b_addr][k*LANE_W +: LANE_W] <= b_wdata[k*LANE_W +: LANE_W];
        end
        for (int k = 0; k < NUM_LANES; k++) begin
            if (a_wr && a_en[k])
                mem[a_addr][k*LANE_W +: LANE_W] <= a_wdata[k*LANE_W +: LANE_W];
        end
        a_q <= mem[a_addr];
        b_q <= mem[b_addr];
    end

endmodule

// File: rtl/dpr_rd_path.sv
// Read output path for one port.
// Stage 1 is the array's read register. An optional stage 2 adds one cycle when pipe is high.
// Each lane's valid flag follows the lane enables captured with the read and is masked by oe.
// Data in invalid lanes is forced to zero. Assumes pipe is held static while reads are in flight.
module dpr_rd_path
    import dpr_pkg::*;
#(
    parameter int WORD_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_go,
    input  lane_t             rd_lanes,
    input  logic              pipe,
    input  logic              oe,
    input  logic [WORD_W-1:0] mem_q,
    output logic [WORD_W-1:0] rdata,
    output logic              rv_hi,
    output logic              rv_lo
);
    localparam int LANE_W = WORD_W / NUM_LANES;

    lane_t             s1_lanes, s2_lanes, cur_lanes;
    logic [WORD_W-1:0] s2_data, cur_data;

    // Stage 1: remember which lanes the read sampled at this edge asked for.
    always_ff @(posedge clk) begin
        if (!rst_n) s1_lanes <= '0;
        else        s1_lanes <= rd_go ? rd_lanes : '0;
    end

    // Stage 2: extra register for pipelined latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_lanes <= '0;
            s2_data  <= '0;
        end else begin
            s2_lanes <= s1_lanes;
            s2_data  <= mem_q;
        end
    end

    // Pick the stage for the chosen latency, then mask the lanes.
    always_comb begin
        cur_lanes = pipe ? s2_lanes : s1_lanes;
        cur_data  = pipe ? s2_data  : mem_q;
        rv_hi     = cur_lanes.hi & oe;
        rv_lo     = cur_lanes.lo & oe;
        rdata     = cur_data & {{LANE_W{rv_hi}}, {LANE_W{rv_lo}}};
    end

endmodule

// File: rtl/dpram_sync_top.sv
// Synchronous true dual-port RAM with a latency select on each port.
// Decodes the chip selects and write strobe of each port and drives the shared array.
// Each port has its own read output path. Left maps to array port A, so the left port wins same-address writes.
module dpram_sync_top
    import dpr_pkg::*;
#(
    parameter int WORD_W = 18,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lf_addr,
    input  logic              lf_we,
    input  logic              lf_ce_n,
    input  logic              lf_ce,
    input  logic              lf_oe,
    input  logic              lf_ub,
    input  logic              lf_lb,
    input  logic              lf_pipe,
    input  logic [WORD_W-1:0] lf_wdata,
    output logic [WORD_W-1:0] lf_rdata,
    output logic              lf_rv_hi,
    output logic              lf_rv_lo,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic              rt_we,
    input  logic              rt_ce_n,
    input  logic              rt_ce,
    input  logic              rt_oe,
    input  logic              rt_ub,
    input  logic              rt_lb,
    input  logic              rt_pipe,
    input  logic [WORD_W-1:0] rt_wdata,
    output logic [WORD_W-1:0] rt_rdata,
    output logic              rt_rv_hi,
    output logic              rt_rv_lo
);
    logic              lf_sel, rt_sel;
    lane_t             lf_lanes, rt_lanes;
    logic [WORD_W-1:0] lf_q, rt_q;

    // Port select decode and lane grouping.
    always_comb begin
        lf_sel   = !lf_ce_n && lf_ce;
        rt_sel   = !rt_ce_n && rt_ce;
        lf_lanes = '{hi: lf_ub, lo: lf_lb};
        rt_lanes = '{hi: rt_ub, lo: rt_lb};
    end

    dpr_array #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .a_wr    (lf_sel && lf_we),
        .a_lanes (lf_lanes),
        .a_addr  (lf_addr),
        .a_wdata (lf_wdata),
        .a_q     (lf_q),
        .b_wr    (rt_sel && rt_we),
        .b_lanes (rt_lanes),
        .b_addr  (rt_addr),
        .b_wdata (rt_wdata),
        .b_q     (rt_q)
    );

    dpr_rd_path #(.WORD_W(WORD_W)) u_lf_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_go    (lf_sel && !lf_we),
        .rd_lanes (lf_lanes),
        .pipe     (lf_pipe),
        .oe       (lf_oe),
        .mem_q    (lf_q),
        .rdata    (lf_rdata),
        .rv_hi    (lf_rv_hi),
        .rv_lo    (lf_rv_lo)
    );

    dpr_rd_path #(.WORD_W(WORD_W)) u_rt_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_go    (rt_sel && !rt_we),
        .rd_lanes (rt_lanes),
        .pipe     (rt_pipe),
        .oe       (rt_oe),
        .mem_q    (rt_q),
        .rdata    (rt_rdata),
        .rv_hi    (rt_rv_hi),
        .rv_lo    (rt_rv_lo)
    );

endmodule

// File: rtl/dpr_port_check.sv
// Per-port protocol checker, bound once to each port of dpram_sync_top.
// Relates the port's control inputs to its valid flags and data across cycles.
// Assumes the latency select is held static while reads are in flight.
module dpr_port_check #(
    parameter int WORD_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              ce,
    input logic              we,
    input logic              ub,
    input logic              lb,
    input logic              oe,
    input logic              pipe,
    input logic [WORD_W-1:0] rdata,
    input logic              rv_hi,
    input logic              rv_lo
);
    localparam int LANE_W = WORD_W / 2;

    logic [1:0] up_cnt;
    logic       sel, rd_hi, rd_lo;

    // Count cycles since reset, saturating, so $past never reaches into reset.
    always_ff @(posedge clk) begin
        if (!rst_n)             up_cnt <= '0;
        else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
    end

    assign sel   = !ce_n && ce;
    assign rd_hi = sel && !we && ub;
    assign rd_lo = sel && !we && lb;

    AST_FT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt >= 2'd1 && !pipe && !$past(pipe) && oe && $past(rd_hi)) |-> rv_hi); // R2

    AST_FT_LATENCY_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt >= 2'd1 && !pipe && !$past(pipe) && oe && $past(rd_lo)) |-> rv_lo); // R2

    AST_PIPE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt >= 2'd2 && pipe && $past(pipe) && $past(pipe, 2) && oe && $past(rd_hi, 2)) |-> rv_hi); // R3

    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt >= 2'd1 && !pipe && !$past(pipe) && !$past(sel)) |-> (!rv_hi && !rv_lo)); // R4

    AST_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rv_lo |-> (rdata[LANE_W-1:0] == '0)); // R6

    AST_LANE_ZERO_HI: assert property (@(posedge clk) disable iff (!rst_n)
        !rv_hi |-> (rdata[WORD_W-1:LANE_W] == '0)); // R6

    AST_OE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (!rv_hi && !rv_lo && rdata == '0)); // R7

endmodule

bind dpram_sync_top dpr_port_check #(.WORD_W(WORD_W)) chk_left (
    .clk   (clk),
    .rst_n (rst_n),
    .ce_n  (lf_ce_n),
    .ce    (lf_ce),
    .we    (lf_we),
    .ub    (lf_ub),
    .lb    (lf_lb),
    .oe    (lf_oe),
    .pipe  (lf_pipe),
    .rdata (lf_rdata),
    .rv_hi (lf_rv_hi),
    .rv_lo (lf_rv_lo)
);

bind dpram_sync_top dpr_port_check #(.WORD_W(WORD_W)) chk_right (
    .clk   (clk),
    .rst_n (rst_n),
    .ce_n  (rt_ce_n),
    .ce    (rt_ce),
    .we    (rt_we),
    .ub    (rt_ub),
    .lb    (rt_lb),
    .oe    (rt_oe),
    .pipe  (rt_pipe),
    .rdata (rt_rdata),
    .rv_hi (rt_rv_hi),
    .rv_lo (rt_rv_lo)
);

// File: tb/dpram_sync_top_test.sv
// Scoreboard bench for dpram_sync_top.
// The driver computes each read's expected word from a reference array and queues it with the cycle it is due.
// The monitor checks every port on every cycle against the queue head, or against idle when nothing is due.
module dpram_sync_top_test;
    localparam int W = 18;
    localparam int A = 6;
    localparam int L = W / 2;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [A-1:0] lf_addr, rt_addr;
    logic         lf_we, lf_ce_n, lf_ce, lf_oe, lf_ub, lf_lb, lf_pipe;
    logic         rt_we, rt_ce_n, rt_ce, rt_oe, rt_ub, rt_lb, rt_pipe;
    logic [W-1:0] lf_wdata, rt_wdata, lf_rdata, rt_rdata;
    logic         lf_rv_hi, lf_rv_lo, rt_rv_hi, rt_rv_lo;

    dpram_sync_top #(.WORD_W(W), .ADDR_W(A)) uut (
        .clk(clk), .rst_n(rst_n),
        .lf_addr(lf_addr), .lf_we(lf_we), .lf_ce_n(lf_ce_n), .lf_ce(lf_ce), .lf_oe(lf_oe),
        .lf_ub(lf_ub), .lf_lb(lf_lb), .lf_pipe(lf_pipe), .lf_wdata(lf_wdata),
        .lf_rdata(lf_rdata), .lf_rv_hi(lf_rv_hi), .lf_rv_lo(lf_rv_lo),
        .rt_addr(rt_addr), .rt_we(rt_we), .rt_ce_n(rt_ce_n), .rt_ce(rt_ce), .rt_oe(rt_oe),
        .rt_ub(rt_ub), .rt_lb(rt_lb), .rt_pipe(rt_pipe), .rt_wdata(rt_wdata),
        .rt_rdata(rt_rdata), .rt_rv_hi(rt_rv_hi), .rt_rv_lo(rt_rv_lo)
    );

    always #5 clk = ~clk;

    typedef struct {
        int           due;
        logic         hi;
        logic         lo;
        logic [W-1:0] data;
        string        req;
    } exp_t;

    exp_t         ql[$];
    exp_t         qr[$];
    logic [W-1:0] ref_mem [1 << A];
    int           cyc   = 0;
    int           nchk  = 0;
    int           nfail = 0;
    string        cur_req = "none";
    bit           done = 0;

    function automatic logic [W-1:0] pat(input int i);
        logic [31:0] t;
        t = i * 32'd40503 + 32'h0002B7C5;
        return t[W-1:0];
    endfunction

    task automatic report();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    task automatic lf_set(input logic we, input logic ce_n, input logic ce, input logic ub,
                          input logic lb, input logic [A-1:0] a, input logic [W-1:0] d);
        lf_we = we; lf_ce_n = ce_n; lf_ce = ce; lf_ub = ub; lf_lb = lb; lf_addr = a; lf_wdata = d;
    endtask

    task automatic rt_set(input logic we, input logic ce_n, input logic ce, input logic ub,
                          input logic lb, input logic [A-1:0] a, input logic [W-1:0] d);
        rt_we = we; rt_ce_n = ce_n; rt_ce = ce; rt_ub = ub; rt_lb = lb; rt_addr = a; rt_wdata = d;
    endtask

    task automatic idle_both();
        lf_set(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, '0, '0);
        rt_set(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, '0, '0);
    endtask

    task automatic ref_write(input logic ub, input logic lb, input logic [A-1:0] a,
                             input logic [W-1:0] d);
        if (ub) ref_mem[a][W-1:L] = d[W-1:L];
        if (lb) ref_mem[a][L-1:0] = d[L-1:0];
    endtask

    // Driver: queue expectations for the reads about to be sampled, update the model, advance one cycle.
    task automatic step();
        exp_t e;
        if (!lf_ce_n && lf_ce && !lf_we) begin
            e.due = cyc + 1 + int'(lf_pipe); e.hi = lf_ub; e.lo = lf_lb;
            e.data = ref_mem[lf_addr]; e.req = cur_req;
            ql.push_back(e);
        end
        if (!rt_ce_n && rt_ce && !rt_we) begin
            e.due = cyc + 1 + int'(rt_pipe); e.hi = rt_ub; e.lo = rt_lb;
            e.data = ref_mem[rt_addr]; e.req = cur_req;
            qr.push_back(e);
        end
        if (!rt_ce_n && rt_ce && rt_we) ref_write(rt_ub, rt_lb, rt_addr, rt_wdata);
        if (!lf_ce_n && lf_ce && lf_we) ref_write(lf_ub, lf_lb, lf_addr, lf_wdata);
        @(negedge clk);
    endtask

    task automatic idle_steps(input int n);
        idle_both();
        for (int i = 0; i < n; i++) step();
    endtask

    // Monitor helper: compare one port's outputs with its queue head or with idle.
    task automatic check_side(input bit rs);
        exp_t         e;
        bit           have;
        logic         vh, vl, oe, xh, xl;
        logic [W-1:0] d, xd;
        string        tag;
        have = 1'b0;
        if (rs) begin
            vh = rt_rv_hi; vl = rt_rv_lo; d = rt_rdata; oe = rt_oe;
            if (qr.size() > 0 && qr[0].due == cyc) begin e = qr.pop_front(); have = 1'b1; end
        end else begin
            vh = lf_rv_hi; vl = lf_rv_lo; d = lf_rdata; oe = lf_oe;
            if (ql.size() > 0 && ql[0].due == cyc) begin e = ql.pop_front(); have = 1'b1; end
        end
        xh  = have && e.hi && oe;
        xl  = have && e.lo && oe;
        xd  = have ? (e.data & {{L{xh}}, {L{xl}}}) : '0;
        tag = have ? e.req : "R4 idle";
        nchk++;
        if (vh !== xh || vl !== xl || d !== xd) begin
            nfail++;
            $display("FAIL %s %s port cycle %0d: got hi=%b lo=%b data=%h expected hi=%b lo=%b data=%h",
                     tag, rs ? "right" : "left", cyc, vh, vl, d, xh, xl, xd);
        end
    endtask

    // Monitor: sample both ports 3 ns after each edge.
    always @(posedge clk) begin
        cyc++;
        #3;
        if (rst_n === 1'b1 && !done) begin
            check_side(1'b0);
            check_side(1'b1);
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #200000;
        nchk++; nfail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        report();
    end

    initial begin
        for (int i = 0; i < (1 << A); i++) ref_mem[i] = '0;
        rst_n = 1'b0;
        lf_oe = 1'b1; rt_oe = 1'b1; lf_pipe = 1'b0; rt_pipe = 1'b0;
        idle_both();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: outputs quiet right after reset.
        nchk++;
        if (lf_rv_hi !== 1'b0 || lf_rv_lo !== 1'b0 || rt_rv_hi !== 1'b0 || rt_rv_lo !== 1'b0
            || lf_rdata !== '0 || rt_rdata !== '0) begin
            nfail++;
            $display("FAIL R10 reset: got lf=%b%b rt=%b%b expected 00 00",
                     lf_rv_hi, lf_rv_lo, rt_rv_hi, rt_rv_lo);
        end

        // The memory powers up undefined, so fill every word through both ports.
        cur_req = "fill";
        for (int i = 0; i < 32; i++) begin
            lf_set(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, A'(i), pat(i));
            rt_set(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, A'(i + 32), pat(i + 32));
            step();
        end

        // R2: flow-through back-to-back reads on both ports.
        cur_req = "R2";
        for (int i = 0; i < 16; i++) begin
            lf_set(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, A'(i), '0);
            rt_set(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, A'(i + 32), '0);
            step();
        end
        idle_steps(3);

        // R1: both ports read the same address in the same cycle.
        cur_req = "R1";
        lf_set(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, A'(7), '0);
        rt_set(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, A'(7), '0);
        step();
        lf_set(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, A'(40), '0);
        rt_set(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, A'(40), '0);
        step();
        idle_steps(3);

        // R9: the other port reads old data in the write cycle and new data one cycle later.
        cur_req = "R9";
        lf_set(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, A'(3), 18'h2A5A5);
        rt_set(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, A'(3), '0);
        step();
        lf_set(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, '0, '0);
        step();
        rt_set(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, A'(50), 18'h15A5A);
        lf_set(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, A'(50), '0);
        step();
        rt_set(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, '0, '0);
        step();
        idle_steps(3);

        // R5: lane-masked writes keep the other half of the word.
        cur_req = "R5";
        lf_set(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, A'(10), 18'h3FFFF);
        rt_set(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, A'(11), 18'h3FFFF);
        step();
        lf_set(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, A'(10), '0);
        rt_set(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, A'(11), '0);
        step();
        idle_steps(3);

        // R6: read lane enables set the valid flags and zero the unused half.
        cur_req = "R6";
        lf_set(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, A'(12), '0);
        rt_set(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, A'(12), '0);
        step();
        lf_set(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, A'(13), '0);
        rt_set(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, A'(44), '0);
        step();
        idle_steps(3);

        // R3: pipelined reads on both ports, then a mixed-latency pair.
        cur_req = "R3";
        lf_pipe = 1'b1; rt_pipe = 1'b1;
        idle_steps(3);
        for (int i = 0; i < 16; i++) begin
            lf_set(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, A'(i + 16), '0);
            rt_set(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, A'(i + 48), '0);
            step();
        end
        idle_steps(3);
        rt_pipe = 1'b0;
        idle_steps(3);
        lf_set(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, A'(20), '0);
        rt_set(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, A'(20), '0);
        step();
        idle_steps(3);
        lf_pipe = 1'b0;
        idle_steps(3);

        // R4: writes through a deselected port are dropped, and a deselected read stays quiet.
        cur_req = "R4";
        lf_set(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, A'(21), 18'h01234);
        rt_set(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, A'(22), 18'h04321);
        step();
        lf_set(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, A'(21), '0);
        rt_set(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, A'(22), '0);
        step();
        lf_set(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, A'(21), '0);
        rt_set(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, A'(22), '0);
        step();
        idle_steps(3);

        // R7: output enable low hides a selected read.
        cur_req = "R7";
        lf_oe = 1'b0; rt_oe = 1'b0;
        lf_set(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, A'(5), '0);
        rt_set(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, A'(6), '0);
        step();
        idle_steps(3);
        lf_oe = 1'b1; rt_oe = 1'b1;

        // R8: same-address writes; the left port wins every lane it enables.
        cur_req = "R8";
        lf_set(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, A'(30), 18'h11111);
        rt_set(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, A'(30), 18'h22222);
        step();
        lf_set(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, A'(31), 18'h3C3C3);
        rt_set(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, A'(31), 18'h05A5A);
        step();
        lf_set(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, A'(30), '0);
        rt_set(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, A'(31), '0);
        step();
        idle_steps(4);

        // Every queued read must have been observed.
        nchk++;
        if (ql.size() != 0 || qr.size() != 0) begin
            nfail++;
            $display("FAIL R2 drain: got %0d/%0d unseen reads expected 0/0", ql.size(), qr.size());
        end
        done = 1'b1;
        report();
    end

endmodule